// File: doc/BRIEF.md
# Bankset Search Controller

This block locates a cache block in a last-level cache whose banks are mapped dynamically. The banks form equal groups called banksets. A block whose address selects a given bankset may sit in any peer bank of that group, always in the same set. The controller accepts one lookup at a time. Each lookup carries a bankset number, a set number, a search mode and a ranking of the peer banks from nearest to farthest as seen by the requester.

The controller sends single-cycle probes to the peer banks. It collects their hit or miss replies, which can arrive after any delay and in any order. It then returns either the global number of the bank that holds the block or a miss, together with the number of probes it issued for that lookup. Three probing orders are offered:

- **Serial:** one bank at a time, nearest first.
- **Broadcast:** every peer bank at once.
- **Hybrid:** a parallel group of the nearest banks, then the rest one by one.

A hit is returned as soon as it is seen. The controller does not take a new lookup until every probe it sent has been answered.

Top module: `bankset_search`

## Requirements
- R1: With the default sizes (16 banks, 4 banksets of 4 peers), peer p of bankset s is global bank s*4+p. Probes go only to banks of the requested bankset. Each bank is probed at most once per lookup. The probe set output carries the requested set number.
- R2: In serial mode (mode code 0), at most one probe is outstanding. Probes follow the ranking: slot 0 of the rank vector (bits 1:0) names the nearest peer, slot k sits in bits 2k+1:2k. The next probe is issued only after the previous bank replied with a miss, and probing stops at the first hit.
- R3: In broadcast mode (mode code 1), all four peer banks are probed in the same cycle.
- R4: In hybrid mode (mode code 2), the MIX_GROUP nearest ranked peers (default 2) are probed in the same cycle. Only when all of them have replied with a miss are the remaining peers probed one at a time, in rank order.
- R5: The result reports a hit with the global number of the holding bank. It reports a miss only after every peer bank has replied with a miss.
- R6: A hit result becomes valid in the cycle after the holding bank's reply is sampled, even while replies from other banks are still outstanding.
- R7: A new lookup is not accepted until the result has been taken and every probe of the current lookup has been answered. A reply from a bank that has no probe pending has no effect on the result.
- R8: The probe count equals the number of probes issued for the lookup:
  - serial: rank position of the holder plus 1;
  - broadcast: 4;
  - hybrid: MIX_GROUP if the holder is within the group, otherwise its rank position plus 1;
  - any miss: 4.
- R9: After reset the controller is ready for a request, shows no result and sends no probe. A result stays valid and unchanged until it is accepted.
- R10: Mode code 3 behaves exactly like broadcast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Controller idle and able to take a lookup |
| req_bankset | input | 2 | Bankset number of the lookup |
| req_set | input | 11 | Set number within each peer bank |
| req_mode | input | 2 | 0 serial, 1 broadcast, 2 hybrid, 3 broadcast |
| req_rank | input | 8 | Peer number per closeness slot, slot 0 nearest |
| probe_valid | output | 16 | One-cycle probe pulse per global bank |
| probe_set | output | 11 | Set number carried by the probes |
| resp_valid | input | 16 | Reply strobe per global bank |
| resp_hit | input | 16 | Reply outcome per bank, 1 = block present |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Result accepted |
| res_hit | output | 1 | 1 = block found, 0 = miss |
| res_bank | output | 4 | Global number of the holding bank |
| res_probes | output | 3 | Probes issued for this lookup |

## Verification
The bench sets per-bank reply delays so that, in broadcast, the holding bank answers first while the others are slow. A design that waited for all replies before answering would show the hit late. A design that dropped the slow replies would accept the next lookup with probes still outstanding. Stray hit replies are injected from a peer that is not yet probed and from another bankset. A controller that did not filter against its pending probes would report a false hit. Hybrid lookups with the holder just past the parallel group, and serial lookups with the holder last, expose errors in group size, in probe ordering and in the reported probe count.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    SM_SERIAL = 2'd0,
    SM_BROAD  = 2'd1,
    SM_HYBRID = 2'd2,
    SM_RSVD   = 2'd3
  } srch_mode_e;
endpackage

// File: rtl/bss_slot_lut.sv
// Turns a closeness ranking and a slot window into a mask of peer banks.
module bss_slot_lut #(
  parameter int PEERS  = 4,
  parameter int PEER_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic [PEERS*PEER_W-1:0] rank,
  input  logic [CNT_W-1:0]        first,
  input  logic [CNT_W-1:0]        num,
  output logic [PEERS-1:0]        mask
);
  logic [PEERS-1:0] slot_sel;
  logic [CNT_W:0]   win_end;

  assign win_end = {1'b0, first} + {1'b0, num};

  for (genvar k = 0; k < PEERS; k++) begin : g_slot
    assign slot_sel[k] = ((CNT_W+1)'(k) >= {1'b0, first}) && ((CNT_W+1)'(k) < win_end);
  end

  always_comb begin
    mask = '0;
    for (int k = 0; k < PEERS; k++) begin
      if (slot_sel[k]) mask[rank[k*PEER_W +: PEER_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/bss_reply_filter.sv
// Keeps only replies of the active bankset that match a pending probe.
module bss_reply_filter #(
  parameter int NUM_BANKS = 16,
  parameter int PEERS     = 4,
  parameter int PEER_W    = 2,
  parameter int BS_W      = 2
) (
  input  logic [NUM_BANKS-1:0] resp_valid,
  input  logic [NUM_BANKS-1:0] resp_hit,
  input  logic [BS_W-1:0]      bs,
  input  logic [PEERS-1:0]     pend,
  output logic                 hit_now,
  output logic [PEER_W-1:0]    hit_peer,
  output logic [PEERS-1:0]     pend_after
);
  logic [PEERS-1:0] lane_v, lane_h, taken, hits;

  assign lane_v     = resp_valid[int'(bs)*PEERS +: PEERS];
  assign lane_h     = resp_hit[int'(bs)*PEERS +: PEERS];
  assign taken      = lane_v & pend;
  assign hits       = taken & lane_h;
  assign pend_after = pend & ~taken;
  assign hit_now    = |hits;

  always_comb begin
    hit_peer = '0;
    for (int p = PEERS - 1; p >= 0; p--) begin
      if (hits[p]) hit_peer = PEER_W'(p);
    end
  end
endmodule

// File: rtl/bankset_search.sv
module bankset_search
  import bss_pkg::*;
#(
  parameter int NUM_BANKS    = 16,
  parameter int NUM_BANKSETS = 4,
  parameter int SET_W        = 11,
  parameter int MIX_GROUP    = 2,
  localparam int PEERS  = NUM_BANKS / NUM_BANKSETS,
  localparam int PEER_W = $clog2(PEERS),
  localparam int BS_W   = $clog2(NUM_BANKSETS),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(PEERS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [BS_W-1:0]         req_bankset,
  input  logic [SET_W-1:0]        req_set,
  input  logic [1:0]              req_mode,
  input  logic [PEERS*PEER_W-1:0] req_rank,
  output logic [NUM_BANKS-1:0]    probe_valid,
  output logic [SET_W-1:0]        probe_set,
  input  logic [NUM_BANKS-1:0]    resp_valid,
  input  logic [NUM_BANKS-1:0]    resp_hit,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic                    res_hit,
  output logic [BANK_W-1:0]       res_bank,
  output logic [CNT_W-1:0]        res_probes
);
  logic                    busy_q, reported_q;
  logic [BS_W-1:0]         bs_q;
  srch_mode_e              mode_q, mode_in;
  logic [PEERS*PEER_W-1:0] rank_q;
  logic [CNT_W-1:0]        next_slot_q, cnt_q, grp_size;
  logic [PEERS-1:0]        pend_q, pend_after, peer_mask;
  logic                    hit_now;
  logic [PEER_W-1:0]       hit_peer;
  logic                    accept, issue_serial, report_hit, report_miss, finish;
  logic [NUM_BANKS-1:0]    probe_q;
  logic [SET_W-1:0]        pset_q;
  logic                    rv_q, rh_q;
  logic [BANK_W-1:0]       rb_q;
  logic [CNT_W-1:0]        rp_q;

  assign mode_in   = srch_mode_e'(req_mode);
  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;

  always_comb begin
    case (mode_in)
      SM_SERIAL: grp_size = CNT_W'(1);
      SM_HYBRID: grp_size = CNT_W'(MIX_GROUP);
      default:   grp_size = CNT_W'(PEERS);
    endcase
  end

  bss_slot_lut #(.PEERS(PEERS), .PEER_W(PEER_W), .CNT_W(CNT_W)) u_lut (
    .rank  (accept ? req_rank : rank_q),
    .first (accept ? '0 : next_slot_q),
    .num   (accept ? grp_size : CNT_W'(1)),
    .mask  (peer_mask)
  );

  bss_reply_filter #(.NUM_BANKS(NUM_BANKS), .PEERS(PEERS), .PEER_W(PEER_W), .BS_W(BS_W)) u_filt (
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .bs         (bs_q),
    .pend       (pend_q),
    .hit_now    (hit_now),
    .hit_peer   (hit_peer),
    .pend_after (pend_after)
  );

  assign issue_serial = busy_q && !reported_q && !hit_now && (pend_after == '0)
                        && (next_slot_q < CNT_W'(PEERS));
  assign report_miss  = busy_q && !reported_q && !hit_now && (pend_after == '0)
                        && (next_slot_q == CNT_W'(PEERS));
  assign report_hit   = busy_q && !reported_q && hit_now;
  assign finish       = busy_q && reported_q && (pend_after == '0) && (!rv_q || res_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      reported_q  <= 1'b0;
      bs_q        <= '0;
      mode_q      <= SM_SERIAL;
      rank_q      <= '0;
      next_slot_q <= '0;
      cnt_q       <= '0;
      pend_q      <= '0;
      probe_q     <= '0;
      pset_q      <= '0;
      rv_q        <= 1'b0;
      rh_q        <= 1'b0;
      rb_q        <= '0;
      rp_q        <= '0;
    end else begin
      probe_q <= '0;
      if (rv_q && res_ready) rv_q <= 1'b0;
      if (accept) begin
        busy_q      <= 1'b1;
        reported_q  <= 1'b0;
        bs_q        <= req_bankset;
        mode_q      <= mode_in;
        rank_q      <= req_rank;
        pset_q      <= req_set;
        pend_q      <= peer_mask;
        next_slot_q <= grp_size;
        cnt_q       <= grp_size;
        probe_q     <= NUM_BANKS'(peer_mask) << (int'(req_bankset) * PEERS);
      end else if (busy_q) begin
        pend_q <= pend_after;
        if (issue_serial) begin
          pend_q      <= peer_mask;
          next_slot_q <= next_slot_q + 1'b1;
          cnt_q       <= cnt_q + 1'b1;
          probe_q     <= NUM_BANKS'(peer_mask) << (int'(bs_q) * PEERS);
        end
        if (report_hit || report_miss) begin
          reported_q <= 1'b1;
          rv_q       <= 1'b1;
          rh_q       <= report_hit;
          rb_q       <= report_hit ? {bs_q, hit_peer} : '0;
          rp_q       <= cnt_q;
        end
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  assign probe_valid = probe_q;
  assign probe_set   = pset_q;
  assign res_valid   = rv_q;
  assign res_hit     = rh_q;
  assign res_bank    = rb_q;
  assign res_probes  = rp_q;
endmodule

// File: rtl/bss_search_chk.sv
module bss_search_chk #(
  parameter int NUM_BANKS = 16,
  parameter int PEERS     = 4,
  parameter int BANK_W    = 4,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic [NUM_BANKS-1:0] probe_valid,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_hit,
  input logic [BANK_W-1:0]    res_bank,
  input logic [CNT_W-1:0]     res_probes,
  input logic                 busy,
  input logic [1:0]           mode
);
  // R2
  serial_single_probe_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode == 2'd0) |-> $onehot0(probe_valid));

  // R3
  broadcast_burst_chk: assert property (@(posedge clk) disable iff (rst)
    ((|probe_valid) && mode[0]) |-> ($countones(probe_valid) == PEERS));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_bank)
                                   && $stable(res_probes)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ready);

  // R8
  miss_count_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_probes == CNT_W'(PEERS)));

  // R1
  probe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (|probe_valid) |-> !req_ready);
endmodule

bind bankset_search bss_search_chk #(
  .NUM_BANKS(NUM_BANKS), .PEERS(PEERS), .BANK_W(BANK_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .probe_valid (probe_valid),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_hit     (res_hit),
  .res_bank    (res_bank),
  .res_probes  (res_probes),
  .busy        (busy_q),
  .mode        (mode_q)
);

// File: tb/bankset_search_test.sv
`timescale 1ns/1ps
module bankset_search_test;
  localparam int NB = 16, NS = 4, PR = 4, MIX = 2, SW = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_bankset = '0, req_mode = '0;
  logic [SW-1:0] req_set = '0;
  logic [7:0] req_rank = '0;
  logic [NB-1:0] probe_valid, resp_valid = '0, resp_hit = '0;
  logic [SW-1:0] probe_set;
  logic res_valid, res_ready = 1'b0, res_hit;
  logic [3:0] res_bank;
  logic [2:0] res_probes;

  int vectors = 0, errors = 0, cyc = 0;
  int holder = -1, cur_mode = 0, cur_bs = 0, grp = 1, stray = -1;
  int cur_rank[PR];
  int tmr[NB], lat_fix[NB], pcnt[NB];
  int ord_pos[NB], ord_cyc[NB];
  int nprobe = 0, foreign_err = 0, dup_err = 0, overlap_err = 0, set_err = 0, hit_cyc = 0;
  logic [SW-1:0] cur_set;

  bankset_search #(.NUM_BANKS(NB), .NUM_BANKSETS(NS), .SET_W(SW), .MIX_GROUP(MIX)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bankset(req_bankset), .req_set(req_set), .req_mode(req_mode), .req_rank(req_rank),
    .probe_valid(probe_valid), .probe_set(probe_set), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_bank(res_bank), .res_probes(res_probes)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bank model: replies after a delay, logs probe order.
  always @(negedge clk) begin
    if (!rst) begin
      bit busy_any;
      resp_valid = '0;
      resp_hit   = '0;
      for (int b = 0; b < NB; b++) begin
        if (tmr[b] > 0) begin
          tmr[b]--;
          if (tmr[b] == 0) begin
            resp_valid[b] = 1'b1;
            resp_hit[b]   = (b == holder);
            if (b == holder) hit_cyc = cyc;
          end
        end
      end
      if (stray >= 0) begin
        resp_valid[stray] = 1'b1;
        resp_hit[stray]   = 1'b1;
        stray = -1;
      end
      busy_any = 1'b0;
      for (int b = 0; b < NB; b++) if (tmr[b] > 0) busy_any = 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (probe_valid[b]) begin
          int pos;
          pos = 0;
          for (int k = 0; k < PR; k++) if (cur_rank[k] == b % PR) pos = k;
          if (b / PR != cur_bs) foreign_err++;
          if (probe_set != cur_set) set_err++;
          pcnt[b]++;
          if (pcnt[b] > 1) dup_err++;
          if ((cur_mode == 0 || (cur_mode == 2 && pos >= grp)) && busy_any) overlap_err++;
          if (nprobe < NB) begin
            ord_pos[nprobe] = pos;
            ord_cyc[nprobe] = cyc;
          end
          nprobe++;
          tmr[b] = (lat_fix[b] > 0) ? lat_fix[b] : int'($urandom_range(1, 6));
        end
      end
    end
  end

  function automatic int exp_count(int mode, int hpos);
    if (hpos < 0) return PR;
    if (mode == 0) return hpos + 1;
    if (mode == 2) return (hpos < MIX) ? MIX : hpos + 1;
    return PR;
  endfunction

  task automatic run_search(input int mode, input int bs, input int hpos,
                            input int rk[PR], input int res_dly, input int stray_kind);
    int hpeer, first_cyc, expc;
    bit order_ok;
    cur_mode = mode;
    cur_bs = bs;
    grp = (mode == 0) ? 1 : (mode == 2) ? MIX : PR;
    for (int k = 0; k < PR; k++) cur_rank[k] = rk[k];
    hpeer = (hpos < 0) ? -1 : rk[hpos];
    holder = (hpos < 0) ? -1 : bs * PR + hpeer;
    nprobe = 0; foreign_err = 0; dup_err = 0; overlap_err = 0; set_err = 0;
    for (int b = 0; b < NB; b++) pcnt[b] = 0;
    @(negedge clk);
    cur_set = SW'($urandom);
    req_set = cur_set;
    req_bankset = 2'(bs);
    req_mode = 2'(mode);
    for (int k = 0; k < PR; k++) req_rank[k*2 +: 2] = 2'(rk[k]);
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        bit drained;
        drained = 1'b1;
        for (int b = 0; b < NB; b++) if (tmr[b] != 0) drained = 1'b0;
        chk(drained, "R7 accept only after drain", 0, 1);
        @(posedge clk);
        #1 req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    // R7: stray hit from an unprobed peer or another bankset
    if (stray_kind == 1) stray = bs * PR + rk[PR-1];
    if (stray_kind == 2) stray = ((bs + 1) % NS) * PR;
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    first_cyc = cyc;
    if (hpos >= 0) chk(first_cyc == hit_cyc + 1, "R6 hit reported next cycle", first_cyc, hit_cyc + 1);
    repeat (res_dly) @(negedge clk);
    expc = exp_count(mode, hpos);
    chk(res_hit == (hpos >= 0), "R5 hit flag", int'(res_hit), int'(hpos >= 0));
    if (hpos >= 0) chk(int'(res_bank) == holder, "R1 holder bank number", int'(res_bank), holder);
    chk(int'(res_probes) == expc, "R8 probe count", int'(res_probes), expc);
    chk(nprobe == expc, "R8 probes seen by banks", nprobe, expc);
    chk(foreign_err == 0 && dup_err == 0 && set_err == 0, "R1 probe targets", foreign_err + dup_err + set_err, 0);
    chk(overlap_err == 0, "R2 R4 serial probes wait for replies", overlap_err, 0);
    order_ok = 1'b1;
    for (int n = 0; n < nprobe && n < NB; n++) begin
      if (mode == 0 && ord_pos[n] != n) order_ok = 1'b0;
      if ((mode == 1 || mode == 3) && ord_cyc[n] != ord_cyc[0]) order_ok = 1'b0;
      if (mode == 2) begin
        if (n < MIX && (ord_pos[n] >= MIX || ord_cyc[n] != ord_cyc[0])) order_ok = 1'b0;
        if (n >= MIX && (ord_pos[n] != n || ord_cyc[n] <= ord_cyc[n-1])) order_ok = 1'b0;
      end
    end
    chk(order_ok, (mode == 0) ? "R2 serial order" : (mode == 2) ? "R4 hybrid order" :
        (mode == 1) ? "R3 broadcast burst" : "R10 mode 3 as broadcast", int'(order_ok), 1);
    res_ready = 1'b1;
    @(posedge clk);
    #1 res_ready = 1'b0;
  endtask

  function automatic void shuffle(ref int r[PR]);
    for (int k = 0; k < PR; k++) r[k] = k;
    for (int k = PR - 1; k > 0; k--) begin
      int j, t;
      j = int'($urandom_range(0, k));
      t = r[k]; r[k] = r[j]; r[j] = t;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int rk[PR];
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin tmr[b] = 0; lat_fix[b] = 0; end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R9 reset no result", int'(res_valid), 0);
    chk(probe_valid == '0, "R9 reset no probe", int'(probe_valid), 0);

    rk = '{2, 0, 3, 1};
    run_search(0, 2, -1, rk, 0, 0);   // R2 serial miss
    run_search(0, 1, 3, rk, 0, 0);    // R2 holder last
    run_search(0, 0, 0, rk, 2, 0);    // R9 backpressure
    // R6/R7: broadcast with a fast holder and slow peers
    for (int b = 0; b < NB; b++) lat_fix[b] = 18;
    lat_fix[3 * PR + rk[1]] = 1;
    run_search(1, 3, 1, rk, 0, 0);
    run_search(1, 3, 1, rk, 0, 0);
    for (int b = 0; b < NB; b++) lat_fix[b] = 0;
    run_search(2, 1, 1, rk, 0, 0);    // R4 holder in group
    run_search(2, 1, 2, rk, 0, 0);    // R4 holder just after group
    run_search(2, 2, -1, rk, 1, 0);   // R4 miss
    run_search(3, 0, 2, rk, 0, 0);    // R10
    run_search(3, 2, -1, rk, 0, 0);   // R10 miss
    for (int b = 0; b < NB; b++) lat_fix[b] = 4;
    run_search(0, 2, -1, rk, 0, 1);   // R7 stray from unprobed peer
    run_search(0, 1, -1, rk, 0, 2);   // R7 stray from other bankset
    for (int b = 0; b < NB; b++) lat_fix[b] = 0;

    for (int i = 0; i < 150; i++) begin
      int m, hp;
      shuffle(rk);
      m = int'($urandom_range(0, 3));
      hp = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, PR - 1));
      run_search(m, int'($urandom_range(0, NS - 1)), hp, rk, int'($urandom_range(0, 3)), 0);
    end

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule